// File: doc/BRIEF.md
# Micro-op dispatch queue

This block is a circular queue between instruction decode and an out-of-order backend. Each clock, up to `LANES` instructions are offered on parallel input lanes. Each instruction carries a tag and a micro-op count, and it reserves as many queue entries as its normalized count. An accept chain decides which lanes are taken. It considers the entries free at the start of the cycle and a per-cycle intake limit that software or a neighbour sets on `ipc_limit_i`.

Instructions leave one per clock, in arrival order, through a valid/ready handshake. An instruction's entries are all returned in the clock its handshake completes. The `zero_lat_i` input picks the timing mode. When it is set and the queue is empty, an instruction accepted on lane 0 is offered downstream in the same cycle. When it is clear, every instruction spends at least one clock in the queue. `busy_o` flags that entries are held.

Top module: `uop_dispatch_queue`

## Requirements
- R1: The entry count of an instruction is its micro-op count capped at `DEPTH`; an instruction with a count above `DEPTH` reserves all `DEPTH` entries, and `out_uops_o` reports the capped value.
- R2: An instruction whose micro-op count is 0 reserves exactly one entry, and `out_uops_o` reports 1 for it.
- R3: Lane k is accepted (`in_ready_o[k]`=1) only if it is valid, all lanes below k are accepted in the same cycle, and the summed entry counts of lanes 0..k do not exceed the entries free at the start of the cycle.
- R4: When `ipc_limit_i` is L>0, only lanes with index below L can be accepted in a cycle; L=0 places no limit.
- R5: With `zero_lat_i`=1 and the queue empty, an instruction accepted on lane 0 is presented on `out_valid_o`/`out_tag_o`/`out_uops_o` in the same cycle. If `out_ready_i` is high, it leaves without being stored.
- R6: With `zero_lat_i`=0, an instruction is never presented at the output in the cycle it is accepted.
- R7: Stored instructions leave strictly in arrival order, at most one per clock. While `out_valid_o` is high and `out_ready_i` is low, the presented instruction is held.
- R8: The free-entry count is updated once per clock. It drops by the entries accepted into storage and rises by the entries of the instruction handed off, both in the same clock.
- R9: `busy_o` is 1 exactly when fewer than `DEPTH` entries are free.
- R10: While `rst_ni` is low, the queue is empty, all `DEPTH` entries are free, `busy_o` is 0 and, in delay mode, `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| zero_lat_i | input | 1 | 1: same-cycle pass-through allowed; 0: one-cycle residency |
| ipc_limit_i | input | IPC_W | Maximum instructions taken per cycle, 0 = unlimited |
| in_valid_i | input | LANES | Per-lane instruction valid |
| in_tag_i | input | LANES x TAG_W | Per-lane instruction tag |
| in_uops_i | input | LANES x UOP_W | Per-lane micro-op count |
| in_ready_o | output | LANES | Per-lane accept |
| out_valid_o | output | 1 | Instruction offered downstream |
| out_ready_i | input | 1 | Downstream takes the offered instruction |
| out_tag_o | output | TAG_W | Tag of the offered instruction |
| out_uops_o | output | CNT_W | Entry count of the offered instruction |
| busy_o | output | 1 | Queue holds entries |

## Verification
Allocation and release share a single free-entry update, so the key cases are cycles where new lanes are accepted while the head instruction leaves. The vector table drives both in one clock with different entry counts. It then checks the exact remaining space in the next cycle: a lane that fits only with the released entries must be refused, and one that fits exactly must be taken. The zero-latency bypass also collides with accept, because an instruction accepted on lane 0 can leave in the same cycle. This is judged by `busy_o` staying low and the free space staying whole afterwards.

// File: rtl/udq_pkg.sv
package udq_pkg;
  // Entries an instruction reserves: at least one, never more than the queue.
  function automatic int unsigned norm_entries(int unsigned uops, int unsigned depth);
    if (uops == 0) return 1;
    if (uops > depth) return depth;
    return uops;
  endfunction
endpackage

// File: rtl/udq_accept.sv
module udq_accept #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int UOP_W = 4,
  parameter int CNT_W = 4,
  parameter int IPC_W = 2
) (
  input  logic [CNT_W-1:0]             free_i,
  input  logic [IPC_W-1:0]             lim_i,
  input  logic [LANES-1:0]             valid_i,
  input  logic [LANES-1:0][UOP_W-1:0]  uops_i,
  output logic [LANES-1:0]             acc_o,
  output logic [LANES-1:0][CNT_W-1:0]  norm_o
);
  import udq_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_norm
    assign norm_o[g] = CNT_W'(norm_entries(int'(uops_i[g]), DEPTH));
  end

  // In-order chain: a refused lane blocks all lanes above it.
  always_comb begin
    int unsigned cum;
    logic        chain;
    cum   = 0;
    chain = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      acc_o[k] = chain && valid_i[k]
                 && ((lim_i == '0) || (k < int'(lim_i)))
                 && ((cum + int'(norm_o[k])) <= int'(free_i));
      if (acc_o[k]) cum = cum + int'(norm_o[k]);
      chain = acc_o[k];
    end
  end
endmodule

// File: rtl/udq_ring.sv
module udq_ring #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             wr_en_i,
  input  logic [LANES-1:0][TAG_W-1:0]  wr_tag_i,
  input  logic [LANES-1:0][CNT_W-1:0]  wr_cnt_i,
  input  logic                         pop_i,
  output logic                         empty_o,
  output logic [TAG_W-1:0]             head_tag_o,
  output logic [CNT_W-1:0]             head_cnt_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] occ_q;
  logic [LANES-1:0][PTR_W-1:0] slot;
  logic [CNT_W-1:0] n_push;

  // Enabled lanes pack densely after the tail.
  always_comb begin
    int unsigned c;
    c = 0;
    for (int k = 0; k < LANES; k++) begin
      slot[k] = tail_q + PTR_W'(c);
      if (wr_en_i[k]) c = c + 1;
    end
    n_push = CNT_W'(c);
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_en_i[k]) begin
        tag_q[slot[k]] <= wr_tag_i[k];
        cnt_q[slot[k]] <= wr_cnt_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      tail_q <= tail_q + PTR_W'(n_push);
      if (pop_i) head_q <= head_q + PTR_W'(1);
      occ_q  <= occ_q + n_push - CNT_W'(pop_i);
    end
  end

  assign empty_o    = (occ_q == '0);
  assign head_tag_o = tag_q[head_q];
  assign head_cnt_o = cnt_q[head_q];
endmodule

// File: rtl/udq_free_ctr.sv
module udq_free_ctr #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [LANES-1:0]             alloc_i,
  input  logic [LANES-1:0][CNT_W-1:0]  norm_i,
  input  logic                         rel_i,
  input  logic [CNT_W-1:0]             rel_cnt_i,
  output logic [CNT_W-1:0]             free_o
);
  logic [CNT_W-1:0] free_q, free_n;

  always_comb begin
    int f;
    f = int'(free_q);
    if (rel_i) f = f + int'(rel_cnt_i);
    for (int k = 0; k < LANES; k++)
      if (alloc_i[k]) f = f - int'(norm_i[k]);
    free_n = CNT_W'(f);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= CNT_W'(DEPTH);
    else         free_q <= free_n;
  end

  assign free_o = free_q;
endmodule

// File: rtl/uop_dispatch_queue.sv
module uop_dispatch_queue #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int UOP_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IPC_W = $clog2(LANES + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         zero_lat_i,
  input  logic [IPC_W-1:0]             ipc_limit_i,
  input  logic [LANES-1:0]             in_valid_i,
  input  logic [LANES-1:0][TAG_W-1:0]  in_tag_i,
  input  logic [LANES-1:0][UOP_W-1:0]  in_uops_i,
  output logic [LANES-1:0]             in_ready_o,
  output logic                         out_valid_o,
  input  logic                         out_ready_i,
  output logic [TAG_W-1:0]             out_tag_o,
  output logic [CNT_W-1:0]             out_uops_o,
  output logic                         busy_o
);
  logic [LANES-1:0]            acc, wr_en;
  logic [LANES-1:0][CNT_W-1:0] norm;
  logic [CNT_W-1:0]            free_q, head_cnt;
  logic [TAG_W-1:0]            head_tag;
  logic                        ring_empty, bypass, byp_take, pop;

  udq_accept #(.LANES(LANES), .DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W), .IPC_W(IPC_W))
  u_accept (
    .free_i (free_q), .lim_i (ipc_limit_i), .valid_i (in_valid_i),
    .uops_i (in_uops_i), .acc_o (acc), .norm_o (norm)
  );

  // Same-cycle pass-through only from an empty queue, lane 0.
  assign bypass   = zero_lat_i && ring_empty && acc[0];
  assign byp_take = bypass && out_ready_i;
  assign pop      = out_ready_i && !ring_empty;

  for (genvar g = 0; g < LANES; g++) begin : g_wen
    if (g == 0) begin : g_l0
      assign wr_en[g] = acc[g] && !byp_take;
    end else begin : g_ln
      assign wr_en[g] = acc[g];
    end
  end

  udq_ring #(.LANES(LANES), .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ring (
    .clk_i, .rst_ni, .wr_en_i (wr_en), .wr_tag_i (in_tag_i), .wr_cnt_i (norm),
    .pop_i (pop), .empty_o (ring_empty), .head_tag_o (head_tag), .head_cnt_o (head_cnt)
  );

  udq_free_ctr #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_free (
    .clk_i, .rst_ni, .alloc_i (wr_en), .norm_i (norm),
    .rel_i (pop), .rel_cnt_i (head_cnt), .free_o (free_q)
  );

  assign in_ready_o  = acc;
  assign out_valid_o = ring_empty ? bypass : 1'b1;
  assign out_tag_o   = ring_empty ? in_tag_i[0] : head_tag;
  assign out_uops_o  = ring_empty ? norm[0] : head_cnt;
  assign busy_o      = (free_q != CNT_W'(DEPTH));
endmodule

// File: rtl/uop_dispatch_queue_chk.sv
module uop_dispatch_queue_chk #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  parameter int CNT_W = 4,
  parameter int IPC_W = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         zero_lat_i,
  input logic [IPC_W-1:0]             ipc_limit_i,
  input logic [LANES-1:0]             in_valid_i,
  input logic [LANES-1:0][TAG_W-1:0]  in_tag_i,
  input logic [LANES-1:0]             in_ready_o,
  input logic                         out_valid_o,
  input logic                         out_ready_i,
  input logic [TAG_W-1:0]             out_tag_o,
  input logic [CNT_W-1:0]             out_uops_o,
  input logic                         busy_o,
  input logic [CNT_W-1:0]             free_q
);
  AST_UOPS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_uops_o >= CNT_W'(1)) && (out_uops_o <= CNT_W'(DEPTH))); // R1 R2

  for (genvar g = 1; g < LANES; g++) begin : g_prefix
    AST_IN_ORDER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_ready_o[g] |-> in_ready_o[g-1]); // R3
  end

  AST_IDLE_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && in_valid_i[0]) |-> in_ready_o[0]); // R3

  AST_IPC_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ipc_limit_i != '0) |-> ($countones(in_ready_o) <= int'(ipc_limit_i))); // R4

  AST_ZERO_LAT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_lat_i && !busy_o && in_valid_i[0])
      |-> (out_valid_o && out_tag_o == in_tag_i[0])); // R5

  AST_DELAY_RESIDENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_lat_i && !busy_o) |-> !out_valid_o); // R6

  AST_HOLD_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && out_valid_o && !out_ready_i)
      |=> (out_valid_o && $stable(out_tag_o) && $stable(out_uops_o))); // R7

  AST_FREE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CNT_W'(DEPTH)); // R8
endmodule

bind uop_dispatch_queue uop_dispatch_queue_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W), .IPC_W(IPC_W)
) chk_i (
  .clk_i (clk_i), .rst_ni (rst_ni), .zero_lat_i (zero_lat_i), .ipc_limit_i (ipc_limit_i),
  .in_valid_i (in_valid_i), .in_tag_i (in_tag_i), .in_ready_o (in_ready_o),
  .out_valid_o (out_valid_o), .out_ready_i (out_ready_i), .out_tag_o (out_tag_o),
  .out_uops_o (out_uops_o), .busy_o (busy_o), .free_q (free_q)
);

// File: tb/uop_dispatch_queue_tb_top.sv
module uop_dispatch_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;
  localparam int DEPTH = 8;
  localparam int TAG_W = 8;
  localparam int UOP_W = 4;
  localparam int CNT_W = 4;
  localparam int IPC_W = 2;
  localparam int NVEC  = 25;

  typedef struct packed {
    logic       zl;
    logic [1:0] lim;
    logic       v0; logic [7:0] t0; logic [3:0] u0;
    logic       v1; logic [7:0] t1; logic [3:0] u1;
    logic       ordy;
    logic [1:0] er;
    logic       eov; logic [7:0] etag; logic [3:0] eu;
    logic       ebusy;
  } vec_t;

  // One row per clock; expectations are the combinational outputs before the edge.
  localparam vec_t TBL [NVEC] = '{
    '{1'b0,2'd0,1'b1,8'h11,4'd3, 1'b1,8'h12,4'd0, 1'b0,2'b11,1'b0,8'h00,4'd0,1'b0}, // R6 R2
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b0,2'b00,1'b1,8'h11,4'd3,1'b1},
    '{1'b0,2'd0,1'b1,8'h13,4'd5, 1'b1,8'h14,4'd1, 1'b1,2'b00,1'b1,8'h11,4'd3,1'b1}, // R3 no space
    '{1'b0,2'd0,1'b1,8'h13,4'd5, 1'b1,8'h14,4'd1, 1'b0,2'b11,1'b1,8'h12,4'd1,1'b1}, // R8 release seen
    '{1'b0,2'd0,1'b1,8'h15,4'd1, 1'b0,8'h00,4'd0, 1'b1,2'b01,1'b1,8'h12,4'd1,1'b1}, // R3 exact fit
    '{1'b0,2'd1,1'b1,8'h16,4'd0, 1'b1,8'h17,4'd0, 1'b1,2'b01,1'b1,8'h13,4'd5,1'b1}, // R4
    '{1'b0,2'd1,1'b1,8'h18,4'd1, 1'b1,8'h19,4'd1, 1'b1,2'b01,1'b1,8'h14,4'd1,1'b1}, // R4
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h15,4'd1,1'b1}, // R7
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h16,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h18,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b0,2'b00,1'b0,8'h00,4'd0,1'b0}, // R9
    '{1'b1,2'd0,1'b1,8'h20,4'd12,1'b1,8'h21,4'd1, 1'b1,2'b01,1'b1,8'h20,4'd8,1'b0}, // R1 R5
    '{1'b1,2'd0,1'b1,8'h21,4'd1, 1'b1,8'h22,4'd2, 1'b0,2'b11,1'b1,8'h21,4'd1,1'b0}, // R5 stored
    '{1'b1,2'd0,1'b1,8'h23,4'd1, 1'b0,8'h00,4'd0, 1'b1,2'b01,1'b1,8'h21,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h22,4'd2,1'b1},
    '{1'b1,2'd0,1'b1,8'h24,4'd1, 1'b0,8'h00,4'd0, 1'b1,2'b01,1'b1,8'h23,4'd1,1'b1}, // R5 no bypass
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h24,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b0,2'b00,1'b0,8'h00,4'd0,1'b0},
    '{1'b0,2'd2,1'b1,8'h25,4'd8, 1'b1,8'h26,4'd0, 1'b1,2'b01,1'b0,8'h00,4'd0,1'b0}, // R3 full fill
    '{1'b0,2'd0,1'b1,8'h27,4'd1, 1'b0,8'h00,4'd0, 1'b0,2'b00,1'b1,8'h25,4'd8,1'b1}, // R8 zero free
    '{1'b0,2'd0,1'b1,8'h27,4'd1, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h25,4'd8,1'b1},
    '{1'b0,2'd0,1'b1,8'h27,4'd1, 1'b1,8'h28,4'd1, 1'b1,2'b11,1'b0,8'h00,4'd0,1'b0}, // R8 all back
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h27,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b1,8'h28,4'd1,1'b1},
    '{1'b0,2'd0,1'b0,8'h00,4'd0, 1'b0,8'h00,4'd0, 1'b1,2'b00,1'b0,8'h00,4'd0,1'b0}
  };

  logic                        clk_i = 1'b0;
  logic                        rst_ni = 1'b0;
  logic                        zero_lat_i = 1'b0;
  logic [IPC_W-1:0]            ipc_limit_i = '0;
  logic [LANES-1:0]            in_valid_i = '0;
  logic [LANES-1:0][TAG_W-1:0] in_tag_i = '0;
  logic [LANES-1:0][UOP_W-1:0] in_uops_i = '0;
  logic [LANES-1:0]            in_ready_o;
  logic                        out_valid_o;
  logic                        out_ready_i = 1'b0;
  logic [TAG_W-1:0]            out_tag_o;
  logic [CNT_W-1:0]            out_uops_o;
  logic                        busy_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uop_dispatch_queue #(.LANES(LANES), .DEPTH(DEPTH), .TAG_W(TAG_W), .UOP_W(UOP_W)) dut_i (
    .clk_i, .rst_ni, .zero_lat_i, .ipc_limit_i, .in_valid_i, .in_tag_i, .in_uops_i,
    .in_ready_o, .out_valid_o, .out_ready_i, .out_tag_o, .out_uops_o, .busy_o
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    in_valid_i  = '0;
    in_tag_i    = '0;
    in_uops_i   = '0;
    out_ready_i = 1'b0;
    ipc_limit_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(negedge clk_i);
    #2;
    check("R10 busy in reset", int'(busy_o), 0);
    check("R10 out_valid in reset", int'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #2;
    check("R10 busy after reset", int'(busy_o), 0);
    check("R10 out_valid after reset", int'(out_valid_o), 0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      zero_lat_i    = TBL[i].zl;
      ipc_limit_i   = TBL[i].lim;
      in_valid_i    = {TBL[i].v1, TBL[i].v0};
      in_tag_i[0]   = TBL[i].t0;
      in_tag_i[1]   = TBL[i].t1;
      in_uops_i[0]  = TBL[i].u0;
      in_uops_i[1]  = TBL[i].u1;
      out_ready_i   = TBL[i].ordy;
      #2;
      check("R3 R4 in_ready", int'(in_ready_o), int'(TBL[i].er));
      check("R5 R6 R7 out_valid", int'(out_valid_o), int'(TBL[i].eov));
      if (TBL[i].eov) begin
        check("R7 out_tag", int'(out_tag_o), int'(TBL[i].etag));
        check("R1 R2 out_uops", int'(out_uops_o), int'(TBL[i].eu));
      end
      check("R9 busy", int'(busy_o), int'(TBL[i].ebusy));
    end

    // Directed: a zero-count instruction after a full release reports one entry (R2).
    @(negedge clk_i);
    idle_inputs();
    zero_lat_i = 1'b1;
    in_valid_i = 2'b01;
    in_tag_i[0] = 8'h30;
    in_uops_i[0] = 4'd0;
    #2;
    check("R2 zero count bypass uops", int'(out_uops_o), 1);
    check("R5 zero count bypass tag", int'(out_tag_o), 'h30);

    // Directed: reset with entries held empties the queue (R10).
    @(negedge clk_i);
    idle_inputs();
    zero_lat_i = 1'b0;
    in_valid_i = 2'b11;
    in_tag_i[0] = 8'h31; in_uops_i[0] = 4'd3;
    in_tag_i[1] = 8'h32; in_uops_i[1] = 4'd4;
    @(negedge clk_i);
    idle_inputs();
    #2;
    check("R9 busy with entries held", int'(busy_o), 1);
    rst_ni = 1'b0;
    #1;
    check("R10 busy cleared by reset", int'(busy_o), 0);
    check("R10 out_valid cleared by reset", int'(out_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // Full space is back: an instruction of DEPTH entries fits (R8 R10).
    in_valid_i = 2'b01;
    in_tag_i[0] = 8'h33;
    in_uops_i[0] = 4'd8;
    #2;
    check("R10 full space after reset", int'(in_ready_o), 1);
    @(negedge clk_i);
    idle_inputs();
    #2;
    check("R6 delayed instruction appears", int'(out_tag_o), 'h33);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule